// File: doc/BRIEF.md
# H-Bridge Gate Command Decoder with Fault Latch

This block is the digital gate-control and protection logic for a motor driver built from two half bridges (output A and output B). It turns two polarity commands, a polarity-invert select, a pair of disable inputs of opposite active levels and an enable/sleep input into four gate enables. Each half bridge has one high-side and one low-side enable. Protection flags from analog circuitry are also inputs: undervoltage, overtemperature (with a separate "cooled below release point" flag), short-circuit and a current-limit tri-state request. Together they decide whether the bridge may conduct and what an active-low status flag reports.

The control pins are asynchronous and pass through a configurable-depth synchronizer. Fault flags are synchronous to the block clock. Short-circuit and overtemperature events latch the bridge off until a qualifying disable edge or enable toggle is seen. Undervoltage and current-limit requests only hold the bridge off while they are present. Each half bridge enforces a programmable dead time whenever it moves conduction from one switch to the other.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With the block awake, no disable active, no fault and no current-limit request, output A conducts high (hs_o[0]=1, ls_o[0]=0) when in_a_i is 1 and low (hs_o[0]=0, ls_o[0]=1) when in_a_i is 0. Output B (bit 1) follows in_b_i the same way. hiz_o[n] is 1 exactly when both switches of leg n are off.
- R2: When inv_i is 1, both polarity commands are active-low: each leg takes the opposite state to the one R1 gives.
- R3: When dis_hi_i is 1 or dis_lo_n_i is 0 (and the block is awake), all four switches are off and flag_n_o is 0.
- R4: When en_i is 0, sleep_o is 1, all four switches are off and flag_n_o is 1, whatever the other inputs are.
- R5: While uv_i is 1 (and the block is awake), all switches are off and flag_n_o is 0. When uv_i returns to 0, the outputs resume the commanded state and the flag releases without any clearing action.
- R6: A one-cycle pulse on sc_i or ot_i latches all switches off, regardless of the polarity commands, and holds flag_n_o at 0 while awake.
- R7: The latch clears on a 1-to-0 edge of dis_hi_i, a 0-to-1 edge of dis_lo_n_i, any edge of en_i, or reset. Changing in_a_i, in_b_i or inv_i does not clear it.
- R8: An overtemperature latch is released by a clearing edge only if ot_cool_i is 1 when that edge is seen. Otherwise it stays latched.
- R9: While ilim_i is 1, all switches are off, but flag_n_o is not driven low on that account.
- R10: The high-side and low-side enables of one leg are never 1 together. When a leg changes from one switch to the other, both of its switches are off for at least DEAD_CYC clock cycles.
- R11: After reset, sleep_o is 1, all switches are off, hiz_o is 2'b11 and flag_n_o is 1, until en_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| in_a_i | input | 1 | Polarity command for output A (asynchronous) |
| in_b_i | input | 1 | Polarity command for output B (asynchronous) |
| inv_i | input | 1 | Treat both polarity commands as active-low (asynchronous) |
| dis_hi_i | input | 1 | Active-high disable (asynchronous) |
| dis_lo_n_i | input | 1 | Active-low disable (asynchronous) |
| en_i | input | 1 | 1 = awake, 0 = sleep (asynchronous) |
| uv_i | input | 1 | Undervoltage level, synchronous |
| ot_i | input | 1 | Overtemperature event, synchronous |
| ot_cool_i | input | 1 | Temperature below release point, synchronous |
| sc_i | input | 1 | Short-circuit event, synchronous |
| ilim_i | input | 1 | Current-limit tri-state request, synchronous |
| hs_o | output | 2 | High-side gate enables, bit 0 = output A |
| ls_o | output | 2 | Low-side gate enables, bit 0 = output A |
| hiz_o | output | 2 | Per-output high-impedance indication |
| sleep_o | output | 1 | Block is in sleep |
| flag_n_o | output | 1 | Active-low status flag |

## Verification
The bench targets the clearing rules. A design that cleared on the wrong edge of a disable input, or on a polarity-command change, would release a short-circuit latch too early. One that ignored the cooling flag would restart the bridge while still overheated. It also checks the flag's behaviour in sleep and under current limit: a design that OR-ed every off-condition into the flag would report a fault on a normal current-limit request. A continuous monitor measures the both-off gap on every direction change in each leg, so a dead-time counter loaded one value short, or skipped when a disable intervenes, shows up as a gap that is too short or an overlap.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int NUM_LEGS = 2;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_req_e;

    typedef struct packed {
        logic                         dis_hi_p;
        logic                         dis_lo_p;
        logic                         en_p;
        logic                         sc_lat;
        logic                         ot_lat;
        logic                         sleep;
        logic                         flag_n;
        leg_req_e [NUM_LEGS-1:0]      req;
    } ctrl_state_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] ff_d, ff_q;

    always_comb begin
        ff_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            ff_d[s] = ff_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign sync_o = ff_q[STAGES-1];
endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_e req_i,
    output logic     hs_o,
    output logic     ls_o
);
    localparam int CNT_W = $clog2(DEAD_CYC + 1);

    typedef struct packed {
        leg_req_e   cur;
        logic [CNT_W-1:0] cnt;
    } leg_state_t;

    leg_state_t leg_d, leg_q;

    always_comb begin
        leg_d = leg_q;
        if (leg_q.cnt != '0) leg_d.cnt = leg_q.cnt - 1'b1;
        if (leg_q.cur != req_i) begin
            if (leg_q.cur != LEG_OFF) begin
                leg_d.cur = LEG_OFF;
                leg_d.cnt = CNT_W'(DEAD_CYC - 1);
            end else if (leg_q.cnt == '0) begin
                leg_d.cur = req_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) leg_q <= '{cur: LEG_OFF, cnt: '0};
        else        leg_q <= leg_d;
    end

    assign hs_o = (leg_q.cur == LEG_HIGH);
    assign ls_o = (leg_q.cur == LEG_LOW);

    AST_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && ls_o)); // R10
    AST_HS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_o) |-> !$past(ls_o)); // R10
    AST_LS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_o) |-> !$past(hs_o)); // R10
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hb_pkg::*;
#(
    parameter int DEAD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_a_i,
    input  logic       in_b_i,
    input  logic       inv_i,
    input  logic       dis_hi_i,
    input  logic       dis_lo_n_i,
    input  logic       en_i,
    input  logic       uv_i,
    input  logic       ot_i,
    input  logic       ot_cool_i,
    input  logic       sc_i,
    input  logic       ilim_i,
    output logic [1:0] hs_o,
    output logic [1:0] ls_o,
    output logic [1:0] hiz_o,
    output logic       sleep_o,
    output logic       flag_n_o
);
    localparam int SYNC_W = NUM_LEGS + 4;

    logic [SYNC_W-1:0]   sync_s;
    logic [NUM_LEGS-1:0] pol_s;
    logic                inv_s, dis_hi_s, dis_lo_s, en_s;

    hb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({en_i, dis_lo_n_i, dis_hi_i, inv_i, in_b_i, in_a_i}),
        .sync_o  (sync_s)
    );

    assign pol_s    = sync_s[NUM_LEGS-1:0];
    assign inv_s    = sync_s[NUM_LEGS];
    assign dis_hi_s = sync_s[NUM_LEGS+1];
    assign dis_lo_s = sync_s[NUM_LEGS+2];
    assign en_s     = sync_s[NUM_LEGS+3];

    ctrl_state_t st_d, st_q;
    logic clr_edge, asleep, disabled, latched, bridge_off;

    always_comb begin
        st_d = st_q;
        st_d.dis_hi_p = dis_hi_s;
        st_d.dis_lo_p = dis_lo_s;
        st_d.en_p     = en_s;

        clr_edge = (st_q.dis_hi_p & ~dis_hi_s)
                 | (~st_q.dis_lo_p & dis_lo_s)
                 | (st_q.en_p ^ en_s);
        if (clr_edge) begin
            st_d.sc_lat = 1'b0;
            if (ot_cool_i) st_d.ot_lat = 1'b0;
        end
        if (sc_i) st_d.sc_lat = 1'b1;
        if (ot_i) st_d.ot_lat = 1'b1;

        asleep     = ~en_s;
        disabled   = dis_hi_s | ~dis_lo_s;
        latched    = st_d.sc_lat | st_d.ot_lat;
        bridge_off = asleep | disabled | uv_i | latched | ilim_i;

        st_d.sleep  = asleep;
        st_d.flag_n = asleep | ~(disabled | uv_i | latched);

        for (int i = 0; i < NUM_LEGS; i++) begin
            if (bridge_off)             st_d.req[i] = LEG_OFF;
            else if (pol_s[i] ^ inv_s)  st_d.req[i] = LEG_HIGH;
            else                        st_d.req[i] = LEG_LOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.sleep  <= 1'b1;
            st_q.flag_n <= 1'b1;
            st_q.req    <= {NUM_LEGS{LEG_OFF}};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (st_q.req[g]),
            .hs_o  (hs_o[g]),
            .ls_o  (ls_o[g])
        );
        assign hiz_o[g] = ~(hs_o[g] | ls_o[g]);
    end

    assign sleep_o  = st_q.sleep;
    assign flag_n_o = st_q.flag_n;

    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sleep |=> (hiz_o == '1)); // R4
    AST_LATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sc_lat || st_q.ot_lat) |=> (hiz_o == '1)); // R6
    AST_UV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_i && en_s) |=> !flag_n_o); // R5
    AST_SLEEP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> flag_n_o); // R4
endmodule

// File: tb/hbridge_gate_ctrl_bench.sv
module hbridge_gate_ctrl_bench;
    localparam int DEAD   = 4;
    localparam int SETTLE = DEAD + 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 0, in_b = 0, inv = 0, dis_hi = 0, dis_lo_n = 0, en = 0;
    logic uv = 0, ot = 0, ot_cool = 0, sc = 0, ilim = 0;
    logic [1:0] hs, ls, hiz;
    logic sleep, flag_n;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model state
    logic m_sc = 0, m_ot = 0;
    logic p_dis_hi = 0, p_dis_lo = 0, p_en = 0;

    always #2.5 clk = ~clk;

    hbridge_gate_ctrl #(.DEAD_CYC(DEAD), .SYNC_STAGES(2)) u_hbridge_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .in_a_i(in_a), .in_b_i(in_b), .inv_i(inv),
        .dis_hi_i(dis_hi), .dis_lo_n_i(dis_lo_n), .en_i(en), .uv_i(uv),
        .ot_i(ot), .ot_cool_i(ot_cool), .sc_i(sc), .ilim_i(ilim),
        .hs_o(hs), .ls_o(ls), .hiz_o(hiz), .sleep_o(sleep), .flag_n_o(flag_n)
    );

    // expected {sleep, flag_n, hiz[1:0], ls[1:0], hs[1:0]}
    function automatic logic [7:0] expect_out();
        logic off, dis, lat, ca, cb;
        dis = dis_hi | ~dis_lo_n;
        lat = m_sc | m_ot;
        off = ~en | dis | uv | lat | ilim;
        ca  = in_a ^ inv;
        cb  = in_b ^ inv;
        expect_out[7]   = ~en;
        expect_out[6]   = ~en | ~(dis | uv | lat);
        expect_out[5:4] = off ? 2'b11 : 2'b00;
        expect_out[3:2] = off ? 2'b00 : {~cb, ~ca};
        expect_out[1:0] = off ? 2'b00 : {cb, ca};
    endfunction

    function automatic string auto_tag();
        if (!en)                  return "R4";
        if (dis_hi || !dis_lo_n)  return "R3";
        if (uv)                   return "R5";
        if (m_sc || m_ot)         return "R6";
        if (ilim)                 return "R9";
        if (inv)                  return "R2";
        return "R1";
    endfunction

    task automatic check(input string tag);
        logic [7:0] act, exp_v;
        act   = {sleep, flag_n, hiz, ls, hs};
        exp_v = expect_out();
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: {sleep,flag_n,hiz,ls,hs} actual=%b expected=%b", tag, act, exp_v);
        end
    endtask

    // apply levels, update model clear edges, settle, check
    task automatic step(input logic a, b, iv, d1, d2n, e, u, il, cool, input string tag);
        @(negedge clk);
        in_a = a; in_b = b; inv = iv; dis_hi = d1; dis_lo_n = d2n; en = e;
        uv = u; ilim = il; ot_cool = cool;
        if ((p_dis_hi && !d1) || (!p_dis_lo && d2n) || (p_en != e)) begin
            m_sc = 1'b0;
            if (cool) m_ot = 1'b0;
        end
        p_dis_hi = d1; p_dis_lo = d2n; p_en = e;
        repeat (SETTLE) @(negedge clk);
        check((tag == "") ? auto_tag() : tag);
    endtask

    task automatic pulse(input logic is_sc, input string tag);
        @(negedge clk);
        if (is_sc) begin sc = 1'b1; m_sc = 1'b1; end
        else       begin ot = 1'b1; m_ot = 1'b1; end
        @(negedge clk);
        sc = 1'b0; ot = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check((tag == "") ? auto_tag() : tag);
    endtask

    // R10: overlap and dead-time monitor, per leg
    int  off_cnt [2] = '{0, 0};
    int  last_on [2] = '{0, 0};   // 0 none, 1 high, 2 low
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                if (hs[i] && ls[i]) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R10: leg %0d overlap actual hs=1 ls=1 expected not both", i);
                end else if (hs[i] || ls[i]) begin
                    int t;
                    t = hs[i] ? 1 : 2;
                    if (last_on[i] != 0 && last_on[i] != t) begin
                        n_cmp++;
                        if (off_cnt[i] < DEAD) begin
                            n_bad++;
                            $display("FAIL R10: leg %0d gap actual=%0d expected>=%0d", i, off_cnt[i], DEAD);
                        end
                    end
                    last_on[i] = t;
                    off_cnt[i] = 0;
                end else begin
                    off_cnt[i]++;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'h5eed_0011);
        repeat (4) @(negedge clk);
        check("R11");
        rst_n = 1'b1;
        repeat (SETTLE) @(negedge clk);
        check("R11");

        // directed
        step(1, 0, 0, 0, 1, 1, 0, 0, 0, "R1");
        step(0, 1, 0, 0, 1, 1, 0, 0, 0, "R1");
        step(0, 1, 1, 0, 1, 1, 0, 0, 0, "R2");
        step(1, 1, 1, 0, 1, 1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 1, 1, 0, 1, 0, "R9");
        step(1, 0, 0, 0, 1, 1, 1, 0, 0, "R5");
        step(1, 0, 0, 0, 1, 1, 0, 0, 0, "R5");
        step(1, 0, 0, 1, 1, 1, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 1, 1, 0, 0, 0, "R1");
        pulse(1, "R6");
        step(0, 1, 1, 0, 1, 1, 0, 0, 0, "R7");   // command change must not clear
        step(0, 1, 1, 1, 1, 1, 0, 0, 0, "R7");   // rising dis_hi: no clear
        step(0, 1, 1, 0, 1, 1, 0, 0, 0, "R7");   // falling dis_hi clears
        pulse(0, "R6");
        step(0, 1, 1, 0, 0, 1, 0, 0, 0, "R8");
        step(0, 1, 1, 0, 1, 1, 0, 0, 0, "R8");   // clear edge while hot: stays
        step(0, 1, 1, 0, 0, 1, 0, 0, 1, "R8");
        step(0, 1, 1, 0, 1, 1, 0, 0, 1, "R8");   // cool: released
        pulse(1, "R6");
        step(0, 1, 1, 0, 1, 0, 0, 0, 0, "R4");
        step(0, 1, 1, 0, 1, 1, 0, 0, 0, "R7");   // enable toggle cleared it

        // constrained random
        for (int k = 0; k < 400; k++) begin
            logic d1, d2n, e, u, il, cool;
            d1   = ($urandom_range(0, 9) == 0);
            d2n  = ($urandom_range(0, 9) != 0);
            e    = ($urandom_range(0, 11) != 0);
            u    = ($urandom_range(0, 11) == 0);
            il   = ($urandom_range(0, 9) == 0);
            cool = $urandom_range(0, 1);
            step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                 d1, d2n, e, u, il, cool, "");
            if ($urandom_range(0, 7) == 0) pulse($urandom_range(0, 1), "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule